// File: doc/BRIEF.md
# Paged DMA Address and Count Engine

This block is the transfer datapath of a single DMA channel. Software programs an 8-bit page, a 16-bit start offset and a 16-bit count that is one less than the number of transfers wanted. Each transfer strobe from the bus side moves the channel one unit forward. The block puts out the physical address of the current transfer, a one-cycle terminal-count pulse when the last transfer has been taken, and a residue that says how many bytes are still to go.

A parameter fixes the unit size at build time. In byte mode the page supplies address bits 23:16 and the offset supplies bits 15:0, so the channel sees 64 KB pages. In word mode the offset is moved up one bit, physical bit 0 is always zero, and page bit 0 is dropped, so the channel sees 128 KB pages and moves 16-bit words. In both modes the offset counter wraps inside its page and never carries into the page. If the autoinitialize flag is loaded with the channel, the channel reloads its start values at terminal count and keeps running. Without it, the channel masks itself at terminal count.

Top module: `pg_dma_engine`

## Requirements
- R1: After reset the page, offset and count are all zero, `tc_pulse` is 0, `chan_masked` is 1, and `residue` reads 1 in byte mode and 2 in word mode.
- R2: A cycle with `ld_en` high copies `ld_page`, `ld_addr` and `ld_count` into the channel, latches `ld_autoinit` and clears `chan_masked`; the new values appear on the outputs in the next cycle.
- R3: In byte mode (`SIZE` = XFER_BYTE) `phys_addr[23:16]` is the page and `phys_addr[15:0]` is the current offset.
- R4: In word mode (`SIZE` = XFER_WORD) `phys_addr[0]` is 0, `phys_addr[16:1]` is the current offset, `phys_addr[23:17]` is page bits 7:1, and page bit 0 has no effect on any output.
- R5: A `xfer_stb` on an unmasked channel with no load in the same cycle adds one to the offset and subtracts one from the count, both visible in the next cycle.
- R6: The offset wraps from 0xFFFF to 0x0000 without changing the page; the page bits of `phys_addr` change only after a load.
- R7: A strobe that finds the count at 0x0000 raises `tc_pulse` for exactly the next cycle; a loaded count N yields a pulse on strobe number N+1, including N = 0xFFFF (65536 transfers).
- R8: Without autoinitialize, terminal count steps the offset once more, wraps the count to 0xFFFF and sets `chan_masked`; later strobes change no output and raise no pulse until the next load.
- R9: With autoinitialize, terminal count restores the offset and count to their loaded values and the channel stays unmasked.
- R10: `residue` equals (count + 1) mod 65536 in byte mode and twice that value in word mode, so it reads 0 after a full non-autoinitialized transfer.
- R11: When `ld_en` and `xfer_stb` are high in the same cycle, the load is taken and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load the programmed values this cycle |
| ld_page | input | 8 | Page value to load |
| ld_addr | input | 16 | Start offset to load |
| ld_count | input | 16 | Transfer count minus one to load |
| ld_autoinit | input | 1 | Reload at terminal count instead of masking |
| xfer_stb | input | 1 | One transfer has been carried out |
| phys_addr | output | 24 | Physical address of the current transfer |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| residue | output | 17 | Bytes still to transfer |
| chan_masked | output | 1 | Channel ignores strobes |

## Verification
Two things can fall on one clock edge: a program load and a transfer strobe, and a terminal count with the reload that autoinitialize triggers. The bench drives `ld_en` and `xfer_stb` together while a transfer is under way and expects the freshly loaded values with no pulse, and it strobes autoinitialized channels with counts of zero and one so that the pulse and the reload land on the same edge every one or two strobes. A byte-mode and a word-mode copy share the stimulus and each edge is judged against an arithmetic model of offset, count and mask.

// File: rtl/pg_dma_pkg.sv
package pg_dma_pkg;

    localparam int PG_PAGE_W = 8;
    localparam int PG_OFS_W  = 16;

    typedef enum logic {
        XFER_BYTE = 1'b0,
        XFER_WORD = 1'b1
    } xfer_size_e;

    // Per-cycle decision shared by both counters
    typedef struct packed {
        logic load;
        logic step;
        logic reload;
    } pg_ctl_t;

    function automatic int unsigned page_lsb(input int ofs_w, input xfer_size_e sz);
        return (sz == XFER_WORD) ? ofs_w + 1 : ofs_w;
    endfunction

endpackage

// File: rtl/pg_chan_ctl.sv
module pg_chan_ctl
    import pg_dma_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ld_en,
    input  logic    ld_autoinit,
    input  logic    xfer_stb,
    input  logic    cnt_zero,
    output pg_ctl_t ctl,
    output logic    masked,
    output logic    tc_pulse
);

    logic auto_q;
    logic term;

    always_comb begin
        ctl.load   = ld_en;
        ctl.step   = xfer_stb && !masked && !ld_en;
        term       = ctl.step && cnt_zero;
        ctl.reload = term && auto_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q   <= 1'b0;
            masked   <= 1'b1;
            tc_pulse <= 1'b0;
        end else begin
            tc_pulse <= term;
            if (ld_en) begin
                auto_q <= ld_autoinit;
                masked <= 1'b0;
            end else if (term && !auto_q) begin
                masked <= 1'b1;
            end
        end
    end

    // R7: a pulse only follows an accepted strobe at count zero
    assert_tc_cause_R7: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> ($past(xfer_stb) && $past(cnt_zero) && !$past(ld_en)));

    // R8: once masked, only a load unmasks
    assert_mask_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (masked && !ld_en) |=> masked);

    // R2: a load leaves the channel unmasked
    assert_load_unmask_R2: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> !masked);

    // R8: a masked channel never signals terminal count
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && masked && !ld_en) |-> !tc_pulse);

endmodule

// File: rtl/pg_step_reg.sv
module pg_step_reg
    import pg_dma_pkg::*;
#(
    parameter int W  = 16,
    parameter bit UP = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         reload,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cur
);

    logic [W-1:0] base_q;
    logic [W-1:0] nxt;

    generate
        if (UP) begin : g_up
            assign nxt = cur + W'(1);
        end else begin : g_down
            assign nxt = cur - W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur    <= '0;
        end else if (load) begin
            base_q <= ld_val;
            cur    <= ld_val;
        end else if (reload) begin
            cur <= base_q;
        end else if (step) begin
            cur <= nxt;
        end
    end

    // R9: a reload restores the loaded start value
    assert_reload_base_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && reload && !load) |-> (cur == $past(base_q)));

    // R2: a load shows up unchanged
    assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && load) |-> (cur == $past(ld_val)));

    // R8: without a load, step or reload the value holds
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !load && !step && !reload) |-> $stable(cur));

endmodule

// File: rtl/pg_phys_map.sv
module pg_phys_map
    import pg_dma_pkg::*;
#(
    parameter int         PAGE_W = PG_PAGE_W,
    parameter int         OFS_W  = PG_OFS_W,
    parameter xfer_size_e SIZE   = XFER_BYTE,
    localparam int        PHYS_W = PAGE_W + OFS_W
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [OFS_W-1:0]  ofs,
    output logic [PHYS_W-1:0] phys
);

    generate
        if (SIZE == XFER_WORD) begin : g_word
            logic [PHYS_W-1:0] page_part;
            // page bit 0 lands on the offset MSB position and is cleared
            assign page_part = {page, {OFS_W{1'b0}}} & ~(PHYS_W'(1) << OFS_W);
            assign phys      = page_part | PHYS_W'({ofs, 1'b0});
        end else begin : g_byte
            assign phys = {page, ofs};
        end
    endgenerate

endmodule

// File: rtl/pg_dma_engine.sv
module pg_dma_engine
    import pg_dma_pkg::*;
#(
    parameter int         PAGE_W = PG_PAGE_W,
    parameter int         OFS_W  = PG_OFS_W,
    parameter xfer_size_e SIZE   = XFER_BYTE,
    localparam int        PHYS_W = PAGE_W + OFS_W,
    localparam int        RES_W  = OFS_W + 1,
    localparam int        PG_LSB = page_lsb(OFS_W, SIZE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [PAGE_W-1:0] ld_page,
    input  logic [OFS_W-1:0]  ld_addr,
    input  logic [OFS_W-1:0]  ld_count,
    input  logic              ld_autoinit,
    input  logic              xfer_stb,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              tc_pulse,
    output logic [RES_W-1:0]  residue,
    output logic              chan_masked
);

    pg_ctl_t           ctl;
    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ofs_cur;
    logic [OFS_W-1:0]  cnt_cur;
    logic [OFS_W-1:0]  cnt_p1;
    logic              cnt_zero;

    // Page register: written only by a load, never by the offset carry
    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (ld_en) begin
            page_q <= ld_page;
        end
    end

    assign cnt_zero = (cnt_cur == '0);

    pg_chan_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .ld_en      (ld_en),
        .ld_autoinit(ld_autoinit),
        .xfer_stb   (xfer_stb),
        .cnt_zero   (cnt_zero),
        .ctl        (ctl),
        .masked     (chan_masked),
        .tc_pulse   (tc_pulse)
    );

    pg_step_reg #(.W(OFS_W), .UP(1'b1)) u_ofs (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.load),
        .step  (ctl.step),
        .reload(ctl.reload),
        .ld_val(ld_addr),
        .cur   (ofs_cur)
    );

    pg_step_reg #(.W(OFS_W), .UP(1'b0)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.load),
        .step  (ctl.step),
        .reload(ctl.reload),
        .ld_val(ld_count),
        .cur   (cnt_cur)
    );

    pg_phys_map #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .SIZE(SIZE)) u_map (
        .page(page_q),
        .ofs (ofs_cur),
        .phys(phys_addr)
    );

    // Residue in bytes, 16-bit wrap of count plus one
    assign cnt_p1 = cnt_cur + OFS_W'(1);
    generate
        if (SIZE == XFER_WORD) begin : g_res_word
            assign residue = {cnt_p1, 1'b0};
        end else begin : g_res_byte
            assign residue = {1'b0, cnt_p1};
        end
    endgenerate

    // R6: page bits of the address move only after a load
    assert_page_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !ld_en) |-> $stable(phys_addr[PHYS_W-1:PG_LSB]));

    // R11: a load beats a strobe in the same cycle
    assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && ld_en && xfer_stb) |-> (!tc_pulse && !chan_masked));

    // R10: a terminal count without reload leaves zero residue
    assert_zero_residue_R10: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse && chan_masked) |-> (residue == '0));

endmodule

// File: tb/test_pg_dma_engine.sv
module test_pg_dma_engine;
    import pg_dma_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_page = '0;
    logic [15:0] ld_addr = '0;
    logic [15:0] ld_count = '0;
    logic        ld_autoinit = 1'b0;
    logic        xfer_stb = 1'b0;

    logic [23:0] phys_b, phys_w;
    logic        tc_b, tc_w, msk_b, msk_w;
    logic [16:0] res_b, res_w;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // reference model state
    logic [7:0]  m_page = '0;
    logic [15:0] m_ba = '0, m_bc = '0, m_a = '0, m_c = '0;
    logic        m_mask = 1'b1, m_auto = 1'b0, m_tc = 1'b0;

    always #5 clk = ~clk;

    pg_dma_engine #(.SIZE(XFER_BYTE)) i_pg_dma_engine (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_page(ld_page),
        .ld_addr(ld_addr), .ld_count(ld_count), .ld_autoinit(ld_autoinit),
        .xfer_stb(xfer_stb), .phys_addr(phys_b), .tc_pulse(tc_b),
        .residue(res_b), .chan_masked(msk_b)
    );

    pg_dma_engine #(.SIZE(XFER_WORD)) i_pg_dma_engine_w (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_page(ld_page),
        .ld_addr(ld_addr), .ld_count(ld_count), .ld_autoinit(ld_autoinit),
        .xfer_stb(xfer_stb), .phys_addr(phys_w), .tc_pulse(tc_w),
        .residue(res_w), .chan_masked(msk_w)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [15:0] cp1;
        cp1 = m_c + 16'd1;
        check(tag, "R3 byte addr", 32'(phys_b), 32'({m_page, m_a}));
        check(tag, "R4 word addr", 32'(phys_w), 32'({m_page[7:1], m_a, 1'b0}));
        check(tag, "R7 tc byte", 32'(tc_b), 32'(m_tc));
        check(tag, "R7 tc word", 32'(tc_w), 32'(m_tc));
        check(tag, "R10 residue byte", 32'(res_b), 32'({1'b0, cp1}));
        check(tag, "R10 residue word", 32'(res_w), 32'({cp1, 1'b0}));
        check(tag, "R8 mask byte", 32'(msk_b), 32'(m_mask));
        check(tag, "R8 mask word", 32'(msk_w), 32'(m_mask));
    endtask

    // drive at a falling edge, model the rising edge, compare at next falling edge
    task automatic step(input logic ld, input logic stb, input logic [7:0] pg,
                        input logic [15:0] ad, input logic [15:0] ct,
                        input logic au, input string tag);
        ld_en = ld; xfer_stb = stb; ld_page = pg; ld_addr = ad;
        ld_count = ct; ld_autoinit = au;
        m_tc = 1'b0;
        if (ld) begin
            m_page = pg; m_ba = ad; m_bc = ct; m_a = ad; m_c = ct;
            m_auto = au; m_mask = 1'b0;
        end else if (stb && !m_mask) begin
            if (m_c == 16'h0000) begin
                m_tc = 1'b1;
                if (m_auto) begin
                    m_a = m_ba; m_c = m_bc;
                end else begin
                    m_a = m_a + 16'd1; m_c = m_c - 16'd1; m_mask = 1'b1;
                end
            end else begin
                m_a = m_a + 16'd1; m_c = m_c - 16'd1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        ld_en = 1'b0; xfer_stb = 1'b0;
        compare(tag);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'h5B;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1 reset");

        // strobe on a masked channel after reset has no effect
        step(1'b0, 1'b1, 8'h00, 16'h0, 16'h0, 1'b0, "R8 strobe after reset");

        // load, step, wrap inside the page, terminal count, mask
        step(1'b1, 1'b0, 8'hA5, 16'hFFFE, 16'h0002, 1'b0, "R2 load");
        step(1'b0, 1'b1, 8'h00, 16'h0, 16'h0, 1'b0, "R5 step");
        step(1'b0, 1'b1, 8'h00, 16'h0, 16'h0, 1'b0, "R6 wrap");
        check("R6", "page kept", 32'(phys_b[23:16]), 32'h00A5);
        step(1'b0, 1'b1, 8'h00, 16'h0, 16'h0, 1'b0, "R7 terminal");
        check("R7", "pulse on third strobe", 32'(tc_b), 32'd1);
        step(1'b0, 1'b0, 8'h00, 16'h0, 16'h0, 1'b0, "R7 pulse ends");
        step(1'b0, 1'b1, 8'h00, 16'h0, 16'h0, 1'b0, "R8 ignored strobe");
        check("R8", "residue after done", 32'(res_b), 32'd0);

        // page bit 0 has no effect in word mode
        step(1'b1, 1'b0, 8'h37, 16'h1234, 16'h0010, 1'b0, "R4 odd page");
        check("R4", "word addr bit0", 32'(phys_w[0]), 32'd0);

        // load and strobe together
        step(1'b0, 1'b1, 8'h00, 16'h0, 16'h0, 1'b0, "R5 step");
        step(1'b1, 1'b1, 8'h12, 16'h4000, 16'h0000, 1'b1, "R11 load with strobe");
        check("R11", "fresh offset", 32'(phys_b[15:0]), 32'h4000);

        // autoinit with count 0: tc and reload on every strobe
        for (int k = 0; k < 4; k++)
            step(1'b0, 1'b1, 8'h00, 16'h0, 16'h0, 1'b0, "R9 autoinit count0");
        step(1'b1, 1'b0, 8'hFE, 16'hFFFF, 16'h0001, 1'b1, "R2 load autoinit");
        for (int k = 0; k < 6; k++)
            step(1'b0, 1'b1, 8'h00, 16'h0, 16'h0, 1'b0, "R9 autoinit count1");

        // sweep of counts, start offsets and autoinit with gated strobes
        for (int c = 0; c < 5; c++)
            for (int s = 0; s < 2; s++)
                for (int au = 0; au < 2; au++) begin
                    step(1'b1, 1'b0, 8'(8'h31 + c), (s == 0) ? 16'hFFFD : 16'h8000,
                         16'(c), au[0], "R2 sweep load");
                    for (int k = 0; k < 14; k++) begin
                        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                        step(1'b0, lfsr[0] | lfsr[2], 8'h00, 16'h0, 16'h0, 1'b0,
                             "R5 sweep");
                    end
                end

        // full 65536-transfer run in one page
        step(1'b1, 1'b0, 8'h03, 16'h0000, 16'hFFFF, 1'b0, "R10 full load");
        for (int k = 0; k < 65536; k++)
            step(1'b0, 1'b1, 8'h00, 16'h0, 16'h0, 1'b0, "R10 full run");
        check("R7", "pulse after 65536", 32'(tc_w), 32'd1);
        check("R10", "word residue zero", 32'(res_w), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule